// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog timer with a 16-bit register interface. A slow tick of about 32 kHz, given as a one-cycle enable pulse in the bus clock domain, drives a prescaler that produces half-second steps. A countdown of those steps starts when software enables the timer. The count is renewed only when a two-word key sequence is written to the service register. If the count runs out, the block either drives a latched reset output or only records the event, depending on the mode bit. The block also has a one-time power-down counter that pulses an active-low interrupt, and a software-reset request that is held until a slow tick samples it.

The countdown FSM has states OFF, RUN, HOLD, BITE and QUIET. OFF goes to RUN when the enable bit is set. RUN goes to HOLD while suspend is armed and the low-power input is high, and HOLD goes back to RUN when that input falls. RUN goes to BITE or QUIET on expiry. In RUN and HOLD, a reload or start keeps the current state. The service FSM has states IDLE and ARMED. IDLE goes to ARMED on the first key, and ARMED goes to IDLE on the second key (which reloads the count) or on any other word. The power-down FSM goes from COUNT to FIRE to OFF, or straight from COUNT to OFF when software disables it. The soft-reset FSM goes from IDLE to PEND on a request, from PEND to ACT on the next slow tick, and from ACT back to IDLE on the following tick.

Top module: `seqwdt_top`

## Requirements
- R1: Register offsets are: control 0x0, service 0x2, cause 0x4, misc 0x8. Control holds the timeout field in bits 15:8, mode in bit 3, enable in bit 2 and suspend in bit 0. Bit 4 of control always reads 1, and its other bits read 0. The service offset reads 0. After power-on reset, control reads 0x0010, cause reads 0x0000 and misc reads 0x0001.
- R2: Let N be the timeout field. The watchdog expires on the (N+1)·HALF_TICKS-th slow tick sampled after the clock edge that enabled or reloaded it. The field value in the enabling write is the one used.
- R3: A write of 0x5555 to offset 0x2, with the next service write being 0xAAAA, reloads the count. Any other word, or the two keys in the other order, leaves the count unchanged.
- R4: Once the enable bit is set, a write of 0 to it does not clear it.
- R5: The suspend bit takes its value only from the first control write after reset. When it is 1 and low_pwr is high, slow ticks are not counted. When it is 0, low_pwr has no effect.
- R6: With mode 0, expiry drives wdt_rst_n low, and it stays low until rst_n. With mode 1, wdt_rst_n stays high.
- R7: Expiry makes the cause register read 0x0002. A soft-reset pulse makes it read 0x0001. The value survives rst_n and is cleared only by por_n.
- R8: A timeout field rewritten while the timer runs takes effect only at the next reload.
- R9: pd_irq_n goes low for one clock cycle on the PD_TICKS-th slow tick after reset, after which misc bit 0 reads 0. A misc write of 0x0000 before that point prevents the pulse. A nonzero write has no effect.
- R10: A control write with bit 4 equal to 0 drives sw_rst_n low from the next slow tick until the tick after that. Several such writes within one tick period produce a single pulse.
- R11: A reload that falls on the same edge as the slow tick that would expire the count wins. The new window starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause register |
| rst_n | input | 1 | System reset, active low; clears all other state |
| lf_tick | input | 1 | One-cycle pulse per slow-clock period |
| low_pwr | input | 1 | Low-power mode indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wdt_rst_n | output | 1 | Watchdog reset output, active low |
| sw_rst_n | output | 1 | Software reset output, active low |
| pd_irq_n | output | 1 | Power-down interrupt, active low |

## Verification
Two functions can meet on one clock edge: the service FSM firing its reload, and the prescaler producing the half-second step that would take the count past zero. The bench arms the key early. It then waits for the negedge just before the expiring slow tick and drives the second key on that exact edge. The scoreboard expects no bite on that tick and one full window later, counted from the collision edge.

// File: rtl/seqwdt_pkg.sv
package seqwdt_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam logic [3:0]  ADDR_CTRL  = 4'h0;
    localparam logic [3:0]  ADDR_SVC   = 4'h2;
    localparam logic [3:0]  ADDR_CAUSE = 4'h4;
    localparam logic [3:0]  ADDR_MISC  = 4'h8;

    localparam logic [15:0] KEY_ARM  = 16'h5555;
    localparam logic [15:0] KEY_FIRE = 16'hAAAA;

    localparam int TOUT_W   = 8;
    localparam int TOUT_LSB = 8;
    localparam int B_SUSP   = 0;
    localparam int B_EN     = 2;
    localparam int B_MODE   = 3;
    localparam int B_SRST   = 4;

    typedef enum logic [2:0] {CD_OFF, CD_RUN, CD_HOLD, CD_BITE, CD_QUIET} cd_state_t;
    typedef enum logic       {SV_IDLE, SV_ARMED} sv_state_t;
    typedef enum logic [1:0] {PD_COUNT, PD_FIRE, PD_OFF} pd_state_t;
    typedef enum logic [1:0] {SR_IDLE, SR_PEND, SR_ACT} sr_state_t;
endpackage

// File: rtl/seqwdt_prescaler.sv
module seqwdt_prescaler #(
    parameter int HALF_TICKS = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic half_o
);
    timeunit 1ns; timeprecision 1ps;

    localparam int         W    = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(HALF_TICKS - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (clr_i)            cnt <= '0;
        else if (tick_i && run_i)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign half_o = tick_i && run_i && !clr_i && (cnt == LAST);
endmodule

// File: rtl/seqwdt_service.sv
module seqwdt_service
    import seqwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        reload_o
);
    timeunit 1ns; timeprecision 1ps;

    sv_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SV_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (wr_i) begin
            unique case (state)
                SV_IDLE:  nxt = (data_i == KEY_ARM) ? SV_ARMED : SV_IDLE;
                SV_ARMED: nxt = (data_i == KEY_ARM) ? SV_ARMED : SV_IDLE;
                default:  nxt = SV_IDLE;
            endcase
        end
    end

    always_comb begin
        reload_o = wr_i && (state == SV_ARMED) && (data_i == KEY_FIRE);
    end
endmodule

// File: rtl/seqwdt_countdown.sv
module seqwdt_countdown
    import seqwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              reload_i,
    input  logic [TOUT_W-1:0] load_val_i,
    input  logic              half_i,
    input  logic              pause_i,
    input  logic              quiet_i,
    output logic              load_o,
    output logic              run_o,
    output logic              expire_o,
    output logic              wdt_rst_n_o
);
    timeunit 1ns; timeprecision 1ps;

    cd_state_t         state, nxt;
    logic [TOUT_W-1:0] cnt;
    logic              load;

    always_comb begin
        unique case (state)
            CD_OFF:          load = start_i;
            CD_RUN, CD_HOLD: load = start_i || reload_i;
            default:         load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= load_val_i;
        else if (half_i && cnt != '0)  cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CD_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CD_OFF:   if (start_i) nxt = CD_RUN;
            CD_RUN: begin
                if (load)                        nxt = CD_RUN;
                else if (pause_i)                nxt = CD_HOLD;
                else if (half_i && cnt == '0)    nxt = quiet_i ? CD_QUIET : CD_BITE;
            end
            CD_HOLD:  if (!pause_i) nxt = CD_RUN;
            CD_BITE:  nxt = CD_BITE;
            CD_QUIET: nxt = CD_QUIET;
            default:  nxt = CD_OFF;
        endcase
    end

    always_comb begin
        load_o      = load;
        run_o       = (state == CD_RUN) && !pause_i;
        expire_o    = (state == CD_RUN) && !load && half_i && (cnt == '0);
        wdt_rst_n_o = (state != CD_BITE);
    end

    assert_cnt_rise_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > $past(cnt)) |-> $past(load));
    assert_frozen_in_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !load) |=> $stable(cnt));
    assert_bite_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_rst_n_o |=> !wdt_rst_n_o);
endmodule

// File: rtl/seqwdt_pdcnt.sv
module seqwdt_pdcnt
    import seqwdt_pkg::*;
#(
    parameter int PD_TICKS = 524288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic kill_i,
    output logic irq_n_o,
    output logic active_o
);
    timeunit 1ns; timeprecision 1ps;

    localparam int           CW   = $clog2(PD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PD_TICKS - 1);

    pd_state_t     state, nxt;
    logic [CW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                pcnt <= '0;
        else if (state == PD_COUNT && tick_i)      pcnt <= pcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PD_COUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PD_COUNT: begin
                if (kill_i)                       nxt = PD_OFF;
                else if (tick_i && pcnt == LAST)  nxt = PD_FIRE;
            end
            PD_FIRE:  nxt = PD_OFF;
            PD_OFF:   nxt = PD_OFF;
            default:  nxt = PD_OFF;
        endcase
    end

    always_comb begin
        irq_n_o  = (state != PD_FIRE);
        active_o = (state == PD_COUNT);
    end

    assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |=> irq_n_o);
endmodule

// File: rtl/seqwdt_top.sv
module seqwdt_top
    import seqwdt_pkg::*;
#(
    parameter int HALF_TICKS = 16384,
    parameter int PD_TICKS   = 524288
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        lf_tick,
    input  logic        low_pwr,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdt_rst_n,
    output logic        sw_rst_n,
    output logic        pd_irq_n
);
    timeunit 1ns; timeprecision 1ps;

    logic              ctrl_wr, svc_wr, misc_wr;
    logic [TOUT_W-1:0] tout_q, load_val;
    logic              mode_q, en_q, susp_q, once_q;
    logic [1:0]        cause_q;
    logic              start, reload, load, run, half, expire, pause, kill, pd_active;
    sr_state_t         sr_state, sr_nxt;
    logic              sr_enter;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign svc_wr   = bus_wr && (bus_addr == ADDR_SVC);
    assign misc_wr  = bus_wr && (bus_addr == ADDR_MISC);
    assign start    = ctrl_wr && bus_wdata[B_EN] && !en_q;
    assign load_val = ctrl_wr ? bus_wdata[TOUT_LSB +: TOUT_W] : tout_q;
    assign pause    = susp_q && low_pwr;
    assign kill     = misc_wr && (bus_wdata == 16'h0000);

    // control register: sticky enable, suspend taken from the first write only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tout_q <= '0;
            mode_q <= 1'b0;
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            once_q <= 1'b0;
        end else if (ctrl_wr) begin
            tout_q <= bus_wdata[TOUT_LSB +: TOUT_W];
            mode_q <= bus_wdata[B_MODE];
            en_q   <= en_q | bus_wdata[B_EN];
            if (!once_q) susp_q <= bus_wdata[B_SUSP];
            once_q <= 1'b1;
        end
    end

    // cause register lives in the power-on domain
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                  cause_q <= 2'b00;
        else if (expire || sr_enter) cause_q <= {expire, sr_enter};
    end

    // soft-reset request: held until the slow tick samples it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_state <= SR_IDLE;
        else        sr_state <= sr_nxt;
    end

    always_comb begin
        sr_nxt = sr_state;
        unique case (sr_state)
            SR_IDLE: if (ctrl_wr && !bus_wdata[B_SRST]) sr_nxt = SR_PEND;
            SR_PEND: if (lf_tick) sr_nxt = SR_ACT;
            SR_ACT:  if (lf_tick) sr_nxt = SR_IDLE;
            default: sr_nxt = SR_IDLE;
        endcase
    end

    always_comb begin
        sr_enter = (sr_state == SR_PEND) && lf_tick;
        sw_rst_n = (sr_state != SR_ACT);
    end

    seqwdt_prescaler #(.HALF_TICKS(HALF_TICKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(lf_tick), .run_i(run),
        .clr_i(load), .half_o(half)
    );

    seqwdt_service u_svc (
        .clk(clk), .rst_n(rst_n), .wr_i(svc_wr), .data_i(bus_wdata),
        .reload_o(reload)
    );

    seqwdt_countdown u_cd (
        .clk(clk), .rst_n(rst_n), .start_i(start), .reload_i(reload),
        .load_val_i(load_val), .half_i(half), .pause_i(pause),
        .quiet_i(mode_q), .load_o(load), .run_o(run), .expire_o(expire),
        .wdt_rst_n_o(wdt_rst_n)
    );

    seqwdt_pdcnt #(.PD_TICKS(PD_TICKS)) u_pd (
        .clk(clk), .rst_n(rst_n), .tick_i(lf_tick), .kill_i(kill),
        .irq_n_o(pd_irq_n), .active_o(pd_active)
    );

    always_comb begin
        bus_rdata = 16'h0000;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[TOUT_LSB +: TOUT_W] = tout_q;
                bus_rdata[B_SRST] = 1'b1;
                bus_rdata[B_MODE] = mode_q;
                bus_rdata[B_EN]   = en_q;
                bus_rdata[B_SUSP] = susp_q;
            end
            ADDR_CAUSE: bus_rdata[1:0] = cause_q;
            ADDR_MISC:  bus_rdata[0]   = pd_active;
            default:    bus_rdata = 16'h0000;
        endcase
    end

    assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> en_q);
    assert_suspend_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(once_q) |-> $stable(susp_q));
    assert_srst_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rst_n) |-> $past(lf_tick));
endmodule

// File: tb/seqwdt_top_test.sv
module seqwdt_top_test;
    timeunit 1ns; timeprecision 1ps;

    localparam int HALF = 4;
    localparam int PD   = 40;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        lf_tick = 1'b0, low_pwr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdt_rst_n, sw_rst_n, pd_irq_n;

    seqwdt_top #(.HALF_TICKS(HALF), .PD_TICKS(PD)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .lf_tick(lf_tick),
        .low_pwr(low_pwr), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_n(wdt_rst_n),
        .sw_rst_n(sw_rst_n), .pd_irq_n(pd_irq_n)
    );

    always #2.5 clk = ~clk;

    logic [2:0] div = 3'd0;
    int ticks = 0;
    always @(posedge clk) begin
        div     <= div + 3'd1;
        lf_tick <= (div == 3'd7);
        if (!rst_n)       ticks <= 0;
        else if (lf_tick) ticks <= ticks + 1;
    end

    int n_cmp = 0, n_bad = 0;
    int last_t, lp_t;

    typedef struct { int kind; int tick; string req; } ev_t;
    ev_t sb[$];

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, int tick, string req);
        ev_t e;
        e.kind = kind; e.tick = tick; e.req = req;
        sb.push_back(e);
    endtask

    task automatic got_ev(int kind);
        ev_t e;
        n_cmp++;
        if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL %s: actual unexpected event kind %0d at tick %0d expected none",
                     kind == 0 ? "R6" : (kind == 1 ? "R9" : "R10"), kind, ticks);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.tick != ticks) begin
                n_bad++;
                $display("FAIL %s: actual kind %0d tick %0d expected kind %0d tick %0d",
                         e.req, kind, ticks, e.kind, e.tick);
            end
        end
    endtask

    // monitor: falling edges of the three outputs, sampled at negedge
    logic p_rst = 1'b1, p_irq = 1'b1, p_sr = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_rst && !wdt_rst_n) got_ev(0);
            if (p_irq && !pd_irq_n)  got_ev(1);
            if (p_sr  && !sw_rst_n)  got_ev(2);
        end
        p_rst = wdt_rst_n; p_irq = pd_irq_n; p_sr = sw_rst_n;
    end

    task automatic drain(string req);
        check(req, sb.size(), 0);
        sb.delete();
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        while (lf_tick) @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; last_t = ticks;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_on_tick(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        while (!lf_tick) @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; last_t = ticks + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [3:0] a, int exp, string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic wait_until(int n);
        while (ticks < n) @(negedge clk);
    endtask

    task automatic set_lp(logic v);
        @(negedge clk);
        while (lf_tick) @(negedge clk);
        low_pwr = v; lp_t = ticks;
    endtask

    task automatic do_reset(bit por);
        @(negedge clk);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    always @(posedge clk) begin : watchdog
        static int cyc = 0;
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, a, b, ex;
        // Segment A: reset values, power-down pulse (R1, R9)
        do_reset(1'b1);
        rd_chk(4'h0, 16'h0010, "R1 ctrl reset");
        rd_chk(4'h4, 16'h0000, "R1 cause reset");
        rd_chk(4'h8, 16'h0001, "R1 misc reset");
        rd_chk(4'h2, 16'h0000, "R1 service reads zero");
        check("R6 reset level", int'(wdt_rst_n), 1);
        check("R10 reset level", int'(sw_rst_n), 1);
        wr(4'h8, 16'h0003);
        rd_chk(4'h8, 16'h0001, "R9 nonzero misc ignored");
        expect_ev(1, PD, "R9");
        wait_until(PD + 4);
        rd_chk(4'h8, 16'h0000, "R9 misc after pulse");
        drain("R9");

        // Segment B: wrong key order, sticky enable, bite (R3 R4 R6 R7 R9)
        do_reset(1'b0);
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h0215); t0 = last_t;
        expect_ev(0, t0 + 3*HALF, "R3");
        wait_until(t0 + 4);
        wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234);
        wait_until(t0 + 6);
        wr(4'h0, 16'h0211);
        rd_chk(4'h0, 16'h0215, "R4 enable sticky");
        wait_until(t0 + 3*HALF + 2);
        check("R6 bite low", int'(wdt_rst_n), 0);
        rd_chk(4'h4, 16'h0002, "R7 cause after expiry");
        wait_until(PD + 10);
        check("R6 bite held", int'(wdt_rst_n), 0);
        drain("R9 disabled");

        // Segment C: cause survives rst_n, suspend write-once (R5 R7 R2)
        do_reset(1'b0);
        rd_chk(4'h4, 16'h0002, "R7 survives rst_n");
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h0310);
        wr(4'h0, 16'h0315); t0 = last_t;
        rd_chk(4'h0, 16'h0314, "R5 suspend once");
        expect_ev(0, t0 + 4*HALF, "R5");
        set_lp(1'b1);
        wait_until(lp_t + 6);
        set_lp(1'b0);
        wait_until(t0 + 4*HALF + 2);
        drain("R2");

        // Segment D: suspend pauses counting (R5)
        do_reset(1'b0);
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h0215); t0 = last_t;
        wait_until(t0 + 2);
        set_lp(1'b1); a = lp_t;
        wait_until(a + 5);
        set_lp(1'b0); b = lp_t;
        ex = t0 + 3*HALF + (b - a);
        expect_ev(0, ex, "R5");
        wait_until(ex + 2);
        drain("R5");

        // Segment E: field rewrite, good service, collision (R8 R3 R11)
        do_reset(1'b0);
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h0114); t0 = last_t;
        wait_until(t0 + 3);
        wr(4'h0, 16'h0314);
        wait_until(t0 + 5);
        wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); t1 = last_t;
        wait_until(t1 + 4);
        wr(4'h2, 16'h5555);
        wait_until(t1 + 4*HALF - 1);
        wr_on_tick(4'h2, 16'hAAAA); t2 = last_t;
        check("R11 collision edge", t2, t1 + 4*HALF);
        expect_ev(0, t2 + 4*HALF, "R11");
        wait_until(t2 + 4*HALF + 2);
        drain("R8");

        // Segment F: quiet mode, soft reset (R6 R7 R10)
        do_reset(1'b1);
        rd_chk(4'h4, 16'h0000, "R7 cleared by por_n");
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h001C); t0 = last_t;
        wait_until(t0 + HALF + 2);
        check("R6 quiet mode", int'(wdt_rst_n), 1);
        rd_chk(4'h4, 16'h0002, "R7 quiet expiry");
        wr(4'h0, 16'h000C); t1 = last_t;
        wr(4'h0, 16'h000C);
        expect_ev(2, t1 + 1, "R10");
        wait_until(t1 + 1);
        @(negedge clk);
        check("R10 pulse low", int'(sw_rst_n), 0);
        wait_until(t1 + 3);
        check("R10 pulse ended", int'(sw_rst_n), 1);
        rd_chk(4'h4, 16'h0001, "R7 soft cause");
        rd_chk(4'h0, 16'h001C, "R10 bit reads one");
        drain("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule